// File: doc/BRIEF.md
# Round-Robin Conversion Sequencer

This block drives a shared temperature converter through three channels in a fixed rotation: the on-die sensor first, then the first remote diode, then the second. For each channel it raises a one-cycle start request together with the channel number. It then holds that channel for a fixed conversion window and captures the converter's result at the end of the window. The result is placed in a per-channel value register, and a one-cycle valid strobe tells a downstream limit comparator that a fresh reading is ready.

The rotation is gated by a monitor enable bit from the configuration logic. Because that bit defaults to set, monitoring begins by itself once reset is released. Clearing the bit does not cut off a conversion that is already running: the current window completes and its result is stored, and then the sequencer parks. Setting the bit again always resumes at the local channel. Window lengths are given in milliseconds and scaled by a ticks-per-millisecond parameter. With the defaults, the local window is 44 cycles and each remote window is 128 cycles.

Top module: `rr_conv_seq`

## Requirements
- R1: While reset is asserted, and right after it, conv_start and res_valid are 0, chan_idx is 0, and every value register and res_value read 0.
- R2: While mon_en is 0 and the sequencer is idle, conv_start never pulses and chan_idx stays 0.
- R3: With mon_en held at 1 through reset, the first conv_start (chan_idx 0, local) appears within five cycles of reset release, with no software action.
- R4: Channels are visited in the order 0 (local), 1 (remote 1), 2 (remote 2), and after 2 the rotation wraps back to 0.
- R5: The first res_valid after a start comes LOCAL_MS*TICKS_PER_MS cycles later for channel 0, and REMOTE_MS*TICKS_PER_MS cycles later for channels 1 and 2 (44 and 128 cycles at the defaults).
- R6: conv_result is sampled in the last cycle of a window and stored in the value register of that window's channel, which is values[k*DATA_W +: DATA_W] for channel k. The other two registers keep their contents.
- R7: res_valid lasts exactly one cycle. In that cycle res_chan carries the channel that finished and res_value its stored result. When mon_en is 1, the conv_start of the next channel falls in the same cycle.
- R8: If mon_en drops during a window, that window still runs its full length and stores its result. No further conv_start follows while mon_en stays 0.
- R9: After a stop, setting mon_en again starts the next conversion on channel 0, whichever channel was last converted.
- R10: conv_start is a single-cycle pulse, and chan_idx during the pulse names the channel being started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mon_en | input | 1 | Monitor enable bit; 1 runs the rotation, 0 halts it after the current window |
| conv_result | input | DATA_W | Converter output, sampled in the last cycle of each window |
| chan_idx | output | 2 | Channel currently being converted (0 local, 1 remote 1, 2 remote 2) |
| conv_start | output | 1 | One-cycle start request to the converter |
| values | output | 3*DATA_W | Value registers, channel k at bits k*DATA_W and up |
| res_valid | output | 1 | One-cycle strobe that a result has been stored |
| res_chan | output | 2 | Channel of the result being flagged |
| res_value | output | DATA_W | Result being flagged |

## Verification
Two events can land in the same cycle: the completion of one channel (store plus res_valid) and the start of the next channel. The bench checks on every slot that the valid strobe and the following start share one cycle and carry different channel numbers. The other collision is a disable that arrives in a window's final cycle. The bench drops mon_en exactly then and expects the result to be stored and flagged, but no start to follow. It then checks that the next enable begins at channel 0.

// File: rtl/rr_seq_pkg.sv
package rr_seq_pkg;

  localparam int NUM_CH = 3;
  localparam int CH_W   = 2;

  typedef enum logic [CH_W-1:0] {
    CH_LOCAL = 2'd0,
    CH_REM1  = 2'd1,
    CH_REM2  = 2'd2
  } chan_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } seq_state_e;

  function automatic chan_e next_chan(input chan_e cur);
    chan_e nxt;
    case (cur)
      CH_LOCAL: nxt = CH_REM1;
      CH_REM1:  nxt = CH_REM2;
      default:  nxt = CH_LOCAL;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/rr_rst_sync.sv
module rr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/rr_slot_timer.sv
module rr_slot_timer #(
  parameter int MAX_LEN = 128,
  parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  output logic             expired
);

  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    if (load) begin
      cnt_d = load_len - LEN_W'(1);
    end else begin
      cnt_d = cnt_q - LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

  // window counter can never exceed the longest slot (R5)
  assert_len_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < LEN_W'(MAX_LEN));

  // once expired and not reloaded, the counter stays parked (R5)
  assert_park_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired);

endmodule

// File: rtl/rr_seq_ctrl.sv
module rr_seq_ctrl
  import rr_seq_pkg::*;
#(
  parameter int TICKS_PER_MS = 4,
  parameter int LOCAL_MS     = 11,
  parameter int REMOTE_MS    = 32,
  localparam int LOCAL_LEN   = LOCAL_MS * TICKS_PER_MS,
  localparam int REMOTE_LEN  = REMOTE_MS * TICKS_PER_MS,
  localparam int MAX_LEN     = (LOCAL_LEN > REMOTE_LEN) ? LOCAL_LEN : REMOTE_LEN,
  localparam int LEN_W       = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mon_en,
  input  logic             slot_done,
  output logic             slot_load,
  output logic [LEN_W-1:0] slot_len,
  output logic             wr_en,
  output chan_e            wr_chan,
  output chan_e            chan_o,
  output logic             start_o,
  output logic             valid_o,
  output chan_e            rchan_o
);

  function automatic logic [LEN_W-1:0] len_of(input chan_e c);
    if (c == CH_LOCAL) begin
      return LEN_W'(LOCAL_LEN);
    end
    return LEN_W'(REMOTE_LEN);
  endfunction

  seq_state_e state_q, state_d;
  chan_e      chan_q, chan_d;
  chan_e      rchan_q, rchan_d;
  logic       start_q, start_d;
  logic       valid_q, valid_d;

  always_comb begin
    state_d   = state_q;
    chan_d    = chan_q;
    rchan_d   = rchan_q;
    start_d   = 1'b0;
    valid_d   = 1'b0;
    slot_load = 1'b0;
    slot_len  = len_of(CH_LOCAL);
    wr_en     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (mon_en) begin
          state_d   = ST_CONV;
          chan_d    = CH_LOCAL;
          start_d   = 1'b1;
          slot_load = 1'b1;
          slot_len  = len_of(CH_LOCAL);
        end
      end
      default: begin
        if (slot_done) begin
          wr_en   = 1'b1;
          valid_d = 1'b1;
          rchan_d = chan_q;
          if (mon_en) begin
            chan_d    = next_chan(chan_q);
            start_d   = 1'b1;
            slot_load = 1'b1;
            slot_len  = len_of(next_chan(chan_q));
          end else begin
            state_d = ST_IDLE;
            chan_d  = CH_LOCAL;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chan_q  <= CH_LOCAL;
      rchan_q <= CH_LOCAL;
      start_q <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      rchan_q <= rchan_d;
      start_q <= start_d;
      valid_q <= valid_d;
    end
  end

  assign wr_chan = chan_q;
  assign chan_o  = chan_q;
  assign start_o = start_q;
  assign valid_o = valid_q;
  assign rchan_o = rchan_q;

  // start request lasts one cycle (R10)
  assert_start_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // valid strobe lasts one cycle (R7)
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // a non-local start always follows completion of its predecessor (R4)
  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q && chan_q != CH_LOCAL) |-> (valid_q && next_chan(rchan_q) == chan_q));

  // idle with enable low produces no start (R2)
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !mon_en) |=> !start_q);

  // every store raises the strobe one edge later (R7)
  assert_store_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> valid_q);

endmodule

// File: rtl/rr_value_bank.sv
module rr_value_bank
  import rr_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  chan_e                    wr_chan,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] vals_flat,
  output logic [DATA_W-1:0]        last_value
);

  logic [DATA_W-1:0] val_q [NUM_CH];
  logic [DATA_W-1:0] last_q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic hit;
    assign hit = wr_en && (wr_chan == chan_e'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q[g] <= '0;
      end else if (hit) begin
        val_q[g] <= wr_data;
      end
    end

    assign vals_flat[g*DATA_W +: DATA_W] = val_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
    end else if (wr_en) begin
      last_q <= wr_data;
    end
  end

  assign last_value = last_q;

  // the flagged value matches the register just written (R6)
  assert_store_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (last_q == val_q[$past(wr_chan)]));

  // without a write every register keeps its contents (R6)
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(vals_flat));

endmodule

// File: rtl/rr_conv_seq.sv
module rr_conv_seq
  import rr_seq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int TICKS_PER_MS = 4,
  parameter int LOCAL_MS     = 11,
  parameter int REMOTE_MS    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mon_en,
  input  logic [DATA_W-1:0]        conv_result,
  output logic [1:0]               chan_idx,
  output logic                     conv_start,
  output logic [3*DATA_W-1:0]      values,
  output logic                     res_valid,
  output logic [1:0]               res_chan,
  output logic [DATA_W-1:0]        res_value
);

  localparam int LOCAL_LEN  = LOCAL_MS * TICKS_PER_MS;
  localparam int REMOTE_LEN = REMOTE_MS * TICKS_PER_MS;
  localparam int MAX_LEN    = (LOCAL_LEN > REMOTE_LEN) ? LOCAL_LEN : REMOTE_LEN;
  localparam int LEN_W      = $clog2(MAX_LEN + 1);

  logic             srst_n;
  logic             slot_load;
  logic [LEN_W-1:0] slot_len;
  logic             slot_done;
  logic             wr_en;
  chan_e            wr_chan;
  chan_e            chan_s;
  chan_e            rchan_s;

  rr_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  rr_slot_timer #(
    .MAX_LEN (MAX_LEN),
    .LEN_W   (LEN_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (srst_n),
    .load     (slot_load),
    .load_len (slot_len),
    .expired  (slot_done)
  );

  rr_seq_ctrl #(
    .TICKS_PER_MS (TICKS_PER_MS),
    .LOCAL_MS     (LOCAL_MS),
    .REMOTE_MS    (REMOTE_MS)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (srst_n),
    .mon_en    (mon_en),
    .slot_done (slot_done),
    .slot_load (slot_load),
    .slot_len  (slot_len),
    .wr_en     (wr_en),
    .wr_chan   (wr_chan),
    .chan_o    (chan_s),
    .start_o   (conv_start),
    .valid_o   (res_valid),
    .rchan_o   (rchan_s)
  );

  rr_value_bank #(
    .DATA_W (DATA_W)
  ) u_bank (
    .clk        (clk),
    .rst_n      (srst_n),
    .wr_en      (wr_en),
    .wr_chan    (wr_chan),
    .wr_data    (conv_result),
    .vals_flat  (values),
    .last_value (res_value)
  );

  assign chan_idx = chan_s;
  assign res_chan = rchan_s;

  // a start never names an unused channel code (R10)
  assert_chan_legal_R10: assert property (@(posedge clk) disable iff (!srst_n)
    conv_start |-> (chan_idx != 2'd3));

endmodule

// File: tb/rr_conv_seq_bench.sv
module rr_conv_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int TPM        = 4;
  localparam int LOC_LEN    = 11 * TPM;
  localparam int REM_LEN    = 32 * TPM;
  localparam int NVEC       = 9;

  // each entry: {expected channel, result presented during that window}
  localparam logic [9:0] VEC [NVEC] = '{
    {2'd0, 8'h00}, {2'd1, 8'hFF}, {2'd2, 8'h5A},
    {2'd0, 8'h8B}, {2'd1, 8'h01}, {2'd2, 8'hA5},
    {2'd0, 8'h7F}, {2'd1, 8'h80}, {2'd2, 8'h33}
  };

  logic              clk;
  logic              rst_n;
  logic              mon_en;
  logic [DATA_W-1:0] conv_result;
  logic [1:0]        chan_idx;
  logic              conv_start;
  logic [3*DATA_W-1:0] values;
  logic              res_valid;
  logic [1:0]        res_chan;
  logic [DATA_W-1:0] res_value;

  int checks;
  int failures;
  logic [DATA_W-1:0] exp_vals [3];

  rr_conv_seq #(
    .DATA_W       (DATA_W),
    .TICKS_PER_MS (TPM)
  ) u_rr_conv_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .mon_en      (mon_en),
    .conv_result (conv_result),
    .chan_idx    (chan_idx),
    .conv_start  (conv_start),
    .values      (values),
    .res_valid   (res_valid),
    .res_chan    (res_chan),
    .res_value   (res_value)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_start(input int limit, output int waited);
    waited = 0;
    while (!conv_start && waited < limit) begin
      @(negedge clk);
      waited++;
    end
  endtask

  task automatic check_values(input string tag);
    for (int k = 0; k < 3; k++) begin
      check(values[k*DATA_W +: DATA_W] == exp_vals[k], tag,
            values[k*DATA_W +: DATA_W], exp_vals[k]);
    end
  endtask

  // one full window: start on exp_ch, present res, expect valid after the slot length
  task automatic run_slot(input logic [1:0] exp_ch, input logic [DATA_W-1:0] res);
    int waited;
    int cyc;
    int exp_len;
    exp_len = (exp_ch == 2'd0) ? LOC_LEN : REM_LEN;
    wait_start(2000, waited);
    check(conv_start == 1'b1, "R10 start seen", conv_start, 1);
    check(chan_idx == exp_ch, "R4 channel order", chan_idx, exp_ch);
    conv_result = res;
    cyc = 0;
    @(negedge clk);
    cyc++;
    check(conv_start == 1'b0, "R10 start single cycle", conv_start, 0);
    while (!res_valid && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == exp_len, "R5 window length", cyc, exp_len);
    check(res_chan == exp_ch, "R7 valid channel", res_chan, exp_ch);
    check(res_value == res, "R7 valid value", res_value, res);
    exp_vals[exp_ch] = res;
    check_values("R6 value registers");
    if (mon_en) begin
      check(conv_start == 1'b1, "R7 next start with valid", conv_start, 1);
    end
    conv_result = ~res;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int waited;
    int cyc;
    bit saw;
    checks = 0;
    failures = 0;
    for (int k = 0; k < 3; k++) exp_vals[k] = '0;
    rst_n = 1'b0;
    mon_en = 1'b0;
    conv_result = '0;
    repeat (4) @(negedge clk);

    // R1: state under reset
    check(conv_start == 1'b0, "R1 start in reset", conv_start, 0);
    check(res_valid == 1'b0, "R1 valid in reset", res_valid, 0);
    check(chan_idx == 2'd0, "R1 channel in reset", chan_idx, 0);
    check(res_value == '0, "R1 res_value in reset", res_value, 0);
    check_values("R1 values in reset");

    // R2: released with enable low stays quiet
    rst_n = 1'b1;
    saw = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (conv_start) saw = 1'b1;
    end
    check(!saw, "R2 no start while disabled", saw, 0);
    check(chan_idx == 2'd0, "R2 channel idle", chan_idx, 0);

    // table walk: three full rotations (R4, R5, R6, R7)
    mon_en = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      run_slot(VEC[i][9:8], VEC[i][7:0]);
    end

    // R8: drop enable part way through a remote window
    run_slot(2'd0, 8'h42);
    wait_start(10, waited);
    check(chan_idx == 2'd1, "R8 remote 1 starting", chan_idx, 1);
    conv_result = 8'hC3;
    cyc = 0;
    repeat (5) begin
      @(negedge clk);
      cyc++;
    end
    mon_en = 1'b0;
    while (!res_valid && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == REM_LEN, "R8 window finishes", cyc, REM_LEN);
    check(res_value == 8'hC3, "R8 result stored", res_value, 8'hC3);
    exp_vals[1] = 8'hC3;
    check_values("R8 values after stop");
    check(conv_start == 1'b0, "R8 no start after stop", conv_start, 1'b0);
    saw = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (conv_start) saw = 1'b1;
    end
    check(!saw, "R8 stays idle", saw, 0);
    check(chan_idx == 2'd0, "R9 channel parked at local", chan_idx, 0);

    // R9: re-enable resumes at local; then disable in the final cycle of the window
    mon_en = 1'b1;
    @(negedge clk);
    check(conv_start == 1'b1, "R9 start on re-enable", conv_start, 1);
    check(chan_idx == 2'd0, "R9 restart at local", chan_idx, 0);
    conv_result = 8'h9E;
    repeat (LOC_LEN - 1) @(negedge clk);
    mon_en = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b1, "R7 valid on last-cycle stop", res_valid, 1);
    check(res_value == 8'h9E, "R8 last-cycle result", res_value, 8'h9E);
    check(conv_start == 1'b0, "R8 no start after last-cycle stop", conv_start, 0);
    exp_vals[0] = 8'h9E;
    check_values("R6 values after last-cycle stop");
    @(negedge clk);
    check(res_valid == 1'b0, "R7 valid single cycle", res_valid, 0);

    // R3: enable held through reset starts by itself
    rst_n = 1'b0;
    mon_en = 1'b1;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 3; k++) exp_vals[k] = '0;
    check_values("R1 values cleared by reset");
    rst_n = 1'b1;
    wait_start(5, waited);
    check(conv_start == 1'b1, "R3 automatic start", conv_start, 1);
    check(chan_idx == 2'd0, "R3 first channel local", chan_idx, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule